// File: doc/BRIEF.md
# Veto Bus Pattern Receiver

This block sits behind the read-bus line receiver of a fault-veto station. It recovers bits from a bi-phase coded serial line, gathers them into frames of a start pattern, a 32-bit veto pattern and a parity bit, and keeps the last good pattern in a data register. A valid flag next to that register shows that a fresh, checked pattern is waiting. Reading the register clears the flag. A frame whose parity check fails leaves the stored pattern alone and raises an error flag.

The stored pattern is compared with a selection mask. The select output asserts when the two overlap in at least one bit. An optional persistence filter asks for an overlap on two good frames in a row, so that only long-lived faults reach the output. A sync pulse of fixed length follows every frame that opens with the correct start pattern. A force-zero control makes every received pattern look like all zeros. It is meant for finding a station that corrupts the bus.

Top module: `vbr_receiver_top`

## Requirements
- R1: The line code uses bit cells of 2*HALF_BIT_CLKS clocks with a transition at every cell boundary. A one has an extra transition in mid-cell and a zero has none. Intervals up to 3/2 half-cells count as short, intervals up to 5/2 half-cells count as long, and anything longer is a line error.
- R2: A frame starts at the first decoded one after idle zeros. It carries the 4-bit start pattern 1101, then 32 data bits with the most significant bit first, then one parity bit chosen so that the count of ones over data and parity is even.
- R3: The cycle after a frame's last bit is decoded, a frame with the correct start pattern and correct parity loads `data_out` and sets `data_valid`.
- R4: `rd_strobe` clears `data_valid` and `parity_err` and leaves `data_out` unchanged. When a good frame is stored in the same cycle as `rd_strobe`, `data_valid` ends up set.
- R5: A frame with the correct start pattern and wrong parity sets `parity_err`. It leaves `data_out`, `data_valid` and `select_out` unchanged.
- R6: A frame with a wrong start pattern is ignored. No output changes and no sync pulse is produced.
- R7: At each good frame, `select_out` becomes one exactly when the stored pattern and `sel_mask` have a one in a common bit position. Between good frames it holds its value.
- R8: When `filter_en` is one, `select_out` is set at a good frame only if that frame and the previous good frame both overlap the mask.
- R9: While `force_zero` is one, a good frame stores an all-zero pattern and still sets `data_valid`.
- R10: `sync_pulse` is high for exactly SYNC_CLKS cycles. It starts the cycle after any frame with a correct start pattern, whatever its parity.
- R11: A line error in the middle of a frame abandons that frame. No output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Bi-phase coded read-bus line (asynchronous) |
| force_zero | input | 1 | Make received patterns appear all zero |
| filter_en | input | 1 | Enable two-frame persistence filter |
| sel_mask | input | DATA_W | Selection mask for the select output |
| rd_strobe | input | 1 | One-cycle read of the data register |
| data_out | output | DATA_W | Last good veto pattern |
| data_valid | output | 1 | Fresh pattern since last read |
| parity_err | output | 1 | Parity failure since last read |
| select_out | output | 1 | Pattern overlaps selection mask |
| sync_pulse | output | 1 | Frame-received pulse |

## Verification
A read of the data register can fall in the same cycle as the store of a new good frame. The bench holds `rd_strobe` high for the whole reception and drops it at the first falling clock edge where the sync pulse is seen, so the read's last active cycle is the store cycle itself. The check is that `data_valid` is still one afterwards and that `data_out` holds the new pattern, since a read must never swallow a frame stored in the same cycle.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
   localparam int unsigned VBR_PRE_W  = 4;
   localparam int unsigned VBR_DATA_W = 32;

   typedef enum logic {
      ASM_IDLE    = 1'b0,
      ASM_COLLECT = 1'b1
   } asm_state_t;
endpackage

// File: rtl/vbr_biphase_decoder.sv
module vbr_biphase_decoder #(
   parameter int unsigned HALF_BIT_CLKS = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic bit_stb,
   output logic bit_val,
   output logic err_stb
);
   localparam int unsigned SHORT_MAX = (3 * HALF_BIT_CLKS) / 2;
   localparam int unsigned LONG_MAX  = (5 * HALF_BIT_CLKS) / 2;
   localparam int unsigned GAP_LIM   = LONG_MAX + 1;
   localparam int unsigned CW        = $clog2(GAP_LIM + 1);

   generate
      if (HALF_BIT_CLKS < 4) begin : g_bad_half
         $error("HALF_BIT_CLKS must be at least 4");
      end
   endgenerate

   logic [2:0]    sync_q;
   logic          line_edge;
   logic [CW-1:0] ivl_cnt;
   logic          half_pend;

   assign line_edge = sync_q[2] ^ sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '0;
         ivl_cnt   <= CW'(GAP_LIM);
         half_pend <= 1'b0;
         bit_stb   <= 1'b0;
         bit_val   <= 1'b0;
         err_stb   <= 1'b0;
      end else begin
         sync_q  <= {sync_q[1:0], line_in};
         bit_stb <= 1'b0;
         err_stb <= 1'b0;
         if (line_edge) begin
            ivl_cnt <= CW'(1);
            if (ivl_cnt <= CW'(SHORT_MAX)) begin
               if (half_pend) begin
                  bit_stb   <= 1'b1;
                  bit_val   <= 1'b1;
                  half_pend <= 1'b0;
               end else begin
                  half_pend <= 1'b1;
               end
            end else if (ivl_cnt <= CW'(LONG_MAX)) begin
               if (half_pend) begin
                  err_stb <= 1'b1;
               end else begin
                  bit_stb <= 1'b1;
                  bit_val <= 1'b0;
               end
               half_pend <= 1'b0;
            end else begin
               err_stb   <= 1'b1;
               half_pend <= 1'b0;
            end
         end else begin
            if (ivl_cnt == CW'(GAP_LIM - 1)) begin
               err_stb   <= 1'b1;
               half_pend <= 1'b0;
            end
            if (ivl_cnt != CW'(GAP_LIM)) ivl_cnt <= ivl_cnt + CW'(1);
         end
      end
   end

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bit_stb, err_stb})); // R1
   AST_ONE_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb && bit_val |-> $past(half_pend)); // R1
endmodule

// File: rtl/vbr_frame_assembler.sv
module vbr_frame_assembler
   import vbr_pkg::*;
#(
   parameter int unsigned DATA_W = VBR_DATA_W,
   parameter int unsigned PRE_W  = VBR_PRE_W,
   parameter logic [PRE_W-1:0] PREAMBLE = 4'b1101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              err_stb,
   output logic              frm_done,
   output logic              frm_pre_ok,
   output logic              frm_par_ok,
   output logic [DATA_W-1:0] frm_data
);
   localparam int unsigned FRAME_BITS = PRE_W + DATA_W + 1;
   localparam int unsigned BCW        = $clog2(FRAME_BITS + 1);

   generate
      if (PREAMBLE[PRE_W-1] != 1'b1) begin : g_bad_pre
         $error("PREAMBLE must start with a one");
      end
   endgenerate

   asm_state_t            state;
   logic [FRAME_BITS-1:0] shreg;
   logic [FRAME_BITS-1:0] shnext;
   logic [BCW-1:0]        bcnt;

   assign shnext = {shreg[FRAME_BITS-2:0], bit_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ASM_IDLE;
         shreg      <= '0;
         bcnt       <= '0;
         frm_done   <= 1'b0;
         frm_pre_ok <= 1'b0;
         frm_par_ok <= 1'b0;
         frm_data   <= '0;
      end else begin
         frm_done <= 1'b0;
         if (err_stb) begin
            state <= ASM_IDLE;
         end else if (bit_stb) begin
            case (state)
               ASM_IDLE: begin
                  if (bit_val) begin
                     state <= ASM_COLLECT;
                     shreg <= FRAME_BITS'(1);
                     bcnt  <= BCW'(1);
                  end
               end
               default: begin
                  shreg <= shnext;
                  bcnt  <= bcnt + BCW'(1);
                  if (bcnt == BCW'(FRAME_BITS - 1)) begin
                     state      <= ASM_IDLE;
                     frm_done   <= 1'b1;
                     frm_pre_ok <= (shnext[FRAME_BITS-1 -: PRE_W] == PREAMBLE);
                     frm_par_ok <= ~(^shnext[DATA_W:0]);
                     frm_data   <= shnext[DATA_W:1];
                  end
               end
            endcase
         end
      end
   end

   AST_DONE_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> $past(bit_stb) && !$past(err_stb)); // R2
   AST_ERR_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb |=> !frm_done); // R11
endmodule

// File: rtl/vbr_select_eval.sv
module vbr_select_eval #(
   parameter int unsigned DATA_W         = 32,
   parameter bit          FILTER_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_stb,
   input  logic              filter_en,
   input  logic [DATA_W-1:0] pattern,
   input  logic [DATA_W-1:0] mask,
   output logic              sel_out
);
   logic hit;
   assign hit = |(pattern & mask);

   generate
      if (FILTER_SUPPORT) begin : g_filt
         logic prev_hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_hit <= 1'b0;
               sel_out  <= 1'b0;
            end else if (eval_stb) begin
               prev_hit <= hit;
               sel_out  <= filter_en ? (hit & prev_hit) : hit;
            end
         end
         AST_FILTER_NEEDS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
            eval_stb && filter_en && !prev_hit |=> !sel_out); // R8
      end else begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sel_out <= 1'b0;
            else if (eval_stb) sel_out <= hit;
         end
      end
   endgenerate

   AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_stb |=> $stable(sel_out)); // R7
   AST_NO_HIT_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      eval_stb && !hit |=> !sel_out); // R7
endmodule

// File: rtl/vbr_receiver_top.sv
module vbr_receiver_top
   import vbr_pkg::*;
#(
   parameter int unsigned DATA_W         = VBR_DATA_W,
   parameter int unsigned PRE_W          = VBR_PRE_W,
   parameter logic [PRE_W-1:0] PREAMBLE  = 4'b1101,
   parameter int unsigned HALF_BIT_CLKS  = 125,
   parameter int unsigned SYNC_CLKS      = 9375,
   parameter bit          FILTER_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              force_zero,
   input  logic              filter_en,
   input  logic [DATA_W-1:0] sel_mask,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid,
   output logic              parity_err,
   output logic              select_out,
   output logic              sync_pulse
);
   localparam int unsigned SCW = $clog2(SYNC_CLKS + 1);

   generate
      if (SYNC_CLKS < 1) begin : g_bad_sync
         $error("SYNC_CLKS must be at least 1");
      end
   endgenerate

   logic              bit_stb, bit_val, err_stb;
   logic              frm_done, frm_pre_ok, frm_par_ok;
   logic [DATA_W-1:0] frm_data;
   logic [DATA_W-1:0] pat_in;
   logic              frame_good, frame_seen, frame_bad;
   logic [SCW-1:0]    sync_cnt;

   vbr_biphase_decoder #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) u_dec (
      .clk(clk), .rst_n(rst_n), .line_in(rx_line),
      .bit_stb(bit_stb), .bit_val(bit_val), .err_stb(err_stb)
   );

   vbr_frame_assembler #(.DATA_W(DATA_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)) u_asm (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
      .err_stb(err_stb), .frm_done(frm_done), .frm_pre_ok(frm_pre_ok),
      .frm_par_ok(frm_par_ok), .frm_data(frm_data)
   );

   assign frame_seen = frm_done & frm_pre_ok;
   assign frame_good = frame_seen & frm_par_ok;
   assign frame_bad  = frame_seen & ~frm_par_ok;
   assign pat_in     = force_zero ? '0 : frm_data;

   vbr_select_eval #(.DATA_W(DATA_W), .FILTER_SUPPORT(FILTER_SUPPORT)) u_sel (
      .clk(clk), .rst_n(rst_n), .eval_stb(frame_good), .filter_en(filter_en),
      .pattern(pat_in), .mask(sel_mask), .sel_out(select_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out   <= '0;
         data_valid <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         if (frame_good)     data_out <= pat_in;
         if (frame_good)     data_valid <= 1'b1;
         else if (rd_strobe) data_valid <= 1'b0;
         if (frame_bad)      parity_err <= 1'b1;
         else if (rd_strobe) parity_err <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sync_cnt <= '0;
      else if (frame_seen)      sync_cnt <= SCW'(SYNC_CLKS);
      else if (sync_cnt != '0)  sync_cnt <= sync_cnt - SCW'(1);
   end
   assign sync_pulse = (sync_cnt != '0);

   AST_VALID_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> $past(frame_good)); // R3
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !frame_good |=> !data_valid); // R4
   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_good |=> $stable(data_out)); // R5
   AST_SYNC_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_pulse) |-> $past(frame_seen)); // R10
   AST_ERR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parity_err) |-> $past(frm_done)); // R5
endmodule

// File: tb/vbr_receiver_top_test.sv
module vbr_receiver_top_test;
   localparam int H    = 8;
   localparam int SYNC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_line = 1'b0;
   logic        force_zero = 1'b0;
   logic        filter_en = 1'b0;
   logic [31:0] sel_mask = 32'h0000_0100;
   logic        rd_strobe = 1'b0;
   logic [31:0] data_out;
   logic        data_valid, parity_err, select_out, sync_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int sync_seen = 0;
   int sync_len = 0;
   int last_len = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vbr_receiver_top #(.HALF_BIT_CLKS(H), .SYNC_CLKS(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .force_zero(force_zero),
      .filter_en(filter_en), .sel_mask(sel_mask), .rd_strobe(rd_strobe),
      .data_out(data_out), .data_valid(data_valid), .parity_err(parity_err),
      .select_out(select_out), .sync_pulse(sync_pulse)
   );

   always @(negedge clk) begin
      if (sync_pulse) sync_len = sync_len + 1;
      else if (sync_len != 0) begin
         last_len  = sync_len;
         sync_seen = sync_seen + 1;
         sync_len  = 0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      rx_line = ~rx_line;
      wait_clks(H);
      if (b) rx_line = ~rx_line;
      wait_clks(H);
   endtask

   function automatic logic [36:0] mk_frame(input logic [3:0] pre, input logic [31:0] d,
                                            input bit bad_par);
      return {pre, d, (^d) ^ bad_par};
   endfunction

   task automatic send_frame(input logic [36:0] f);
      wait_clks(3 * H);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      for (int i = 36; i >= 0; i--) send_bit(f[i]);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      wait_clks(SYNC + 10);
   endtask

   task automatic t_reset;
      check("R3 reset data", data_out, 32'h0);
      check("R3 reset valid", data_valid, 1'b0);
      check("R5 reset err", parity_err, 1'b0);
      check("R7 reset select", select_out, 1'b0);
      check("R10 reset sync", sync_pulse, 1'b0);
   endtask

   task automatic t_good_frame;
      int s0 = sync_seen;
      send_frame(mk_frame(4'b1101, 32'h8000_0101, 1'b0));
      check("R2 R3 data", data_out, 32'h8000_0101);
      check("R3 valid", data_valid, 1'b1);
      check("R7 overlap select", select_out, 1'b1);
      check("R10 sync count", sync_seen - s0, 1);
      check("R10 sync width", last_len, SYNC);
   endtask

   task automatic t_read;
      rd_strobe = 1'b1; wait_clks(1); rd_strobe = 1'b0; wait_clks(1);
      check("R4 valid cleared", data_valid, 1'b0);
      check("R4 data kept", data_out, 32'h8000_0101);
   endtask

   task automatic t_no_overlap;
      send_frame(mk_frame(4'b1101, 32'h0F00_0000, 1'b0));
      check("R1 R3 data all-zero-ones mix", data_out, 32'h0F00_0000);
      check("R7 no overlap", select_out, 1'b0);
      rd_strobe = 1'b1; wait_clks(1); rd_strobe = 1'b0; wait_clks(1);
   endtask

   task automatic t_parity;
      int s0 = sync_seen;
      send_frame(mk_frame(4'b1101, 32'h0000_0100, 1'b1));
      check("R5 err set", parity_err, 1'b1);
      check("R5 data kept", data_out, 32'h0F00_0000);
      check("R5 valid kept", data_valid, 1'b0);
      check("R5 select kept", select_out, 1'b0);
      check("R10 sync on parity err", sync_seen - s0, 1);
      rd_strobe = 1'b1; wait_clks(1); rd_strobe = 1'b0; wait_clks(1);
      check("R4 err cleared", parity_err, 1'b0);
   endtask

   task automatic t_bad_pre;
      int s0 = sync_seen;
      send_frame(mk_frame(4'b1001, 32'hFFFF_FFFF, 1'b0));
      check("R6 data kept", data_out, 32'h0F00_0000);
      check("R6 valid kept", data_valid, 1'b0);
      check("R6 err kept", parity_err, 1'b0);
      check("R6 select kept", select_out, 1'b0);
      check("R6 no sync", sync_seen - s0, 0);
   endtask

   task automatic t_gap;
      int s0 = sync_seen;
      logic [36:0] f = mk_frame(4'b1101, 32'h1234_5678, 1'b0);
      wait_clks(3 * H);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      for (int i = 36; i >= 26; i--) send_bit(f[i]);
      wait_clks(10 * H);
      for (int i = 25; i >= 0; i--) send_bit(f[i]);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      wait_clks(SYNC + 10);
      check("R11 data kept", data_out, 32'h0F00_0000);
      check("R11 valid kept", data_valid, 1'b0);
      check("R11 no sync", sync_seen - s0, 0);
   endtask

   task automatic t_force_zero;
      force_zero = 1'b1;
      send_frame(mk_frame(4'b1101, 32'hFFFF_FFFF, 1'b0));
      force_zero = 1'b0;
      check("R9 data zero", data_out, 32'h0);
      check("R9 valid set", data_valid, 1'b1);
      check("R9 select off", select_out, 1'b0);
   endtask

   task automatic t_filter;
      filter_en = 1'b1;
      send_frame(mk_frame(4'b1101, 32'h0000_0100, 1'b0));
      check("R8 first match blocked", select_out, 1'b0);
      send_frame(mk_frame(4'b1101, 32'h0000_0300, 1'b0));
      check("R8 second match passes", select_out, 1'b1);
      send_frame(mk_frame(4'b1101, 32'h0000_0001, 1'b0));
      check("R8 miss drops", select_out, 1'b0);
      filter_en = 1'b0;
   endtask

   task automatic t_collide;
      rd_strobe = 1'b1;
      fork
         send_frame(mk_frame(4'b1101, 32'hA5A5_0000, 1'b0));
         begin
            while (!sync_pulse) @(negedge clk);
            rd_strobe = 1'b0;
         end
      join
      check("R4 store beats read", data_valid, 1'b1);
      check("R4 collide data", data_out, 32'hA5A5_0000);
   endtask

   initial begin
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(2);
      t_reset();
      t_good_frame();
      t_read();
      t_no_overlap();
      t_parity();
      t_bad_pre();
      t_gap();
      t_force_zero();
      t_filter();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait_clks(100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule